// File: doc/BRIEF.md
# Lockable Watermark Sub-Region Access Filter

This block holds the settings of one address window, the sub-region, that sits inside a larger base memory region. It checks every data access against those settings. Software programs three registers through a write-only port: a control word and two bounds, a start address and an end address. An access offers an address, a secure flag and a privileged flag. When the window is switched on and the address falls inside it, the window's own secure and privileged rules decide the outcome. In every other case the decision of the surrounding base region, given on an input, is passed through unchanged.

A lock bit freezes all three registers until the next reset. Only reset can clear it. The reset contents depend on an 8-bit trust-zone enable code. With the inverting code 0xB4, the window comes out of reset covering the whole address space as secure and privileged. With any other code, including the normal code 0xC3, every control bit resets to 0, so the base policy applies everywhere.

The decision is combinational on the access inputs. A configuration write takes effect from the clock edge that captures it.

Top module: `wm_subregion_filter`

## Requirements
- R1: When reset is released with any code other than 0xB4, for example 0xC3, the enable, secure, privileged and lock bits are all 0, so every valid access gets `grant` equal to `base_grant`.
- R2: When reset is released with code 0xB4, the window is enabled, secure and privileged and spans every address (start 0, end 2^AW). Only accesses that are both secure and privileged are granted, whatever `base_grant` says.
- R3: While the enable bit (control bit 0) is 0, accesses inside the start..end bounds get `grant` equal to `base_grant`.
- R4: With enable set and the address inside the window, secure bit 0 (control bit 1) grants only non-secure accesses and secure bit 1 grants only secure accesses.
- R5: With enable set and the address inside the window, privileged bit 0 (control bit 2) admits both privilege levels, while privileged bit 1 admits only privileged accesses.
- R6: An address is inside the window when start <= addr < end. Addresses below start or at or above end get `grant` equal to `base_grant`.
- R7: When end <= start, the window is empty and every access gets `grant` equal to `base_grant`.
- R8: Writes go to offset 0 (control), offset 1 (start, AW bits) and offset 2 (end, AW+1 bits). A write changes the decision only after the rising clock edge that captures it, not before.
- R9: Once lock (control bit 7) is written as 1, later writes to all three offsets are ignored, and the lock stays set until reset.
- R10: `illegal` is 1 exactly when `acc_valid` is 1 and the access is denied. When `acc_valid` is 0, both `grant` and `illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tz_code | input | 8 | Trust-zone enable code; its value while reset is held selects the reset contents |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register offset: 0 control, 1 start, 2 end |
| wr_data | input | DW | Write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | AW | Access address |
| acc_secure | input | 1 | 1 = secure access |
| acc_priv | input | 1 | 1 = privileged access |
| base_grant | input | 1 | Decision of the enclosing base region |
| grant | output | 1 | Access allowed |
| illegal | output | 1 | Access presented and denied |

## Verification
The assertions assume that `tz_code` is stable while reset is asserted. They also assume that `wr_addr` and `wr_data` are only meaningful while `wr_en` is high, and that the access inputs settle away from the clock edge. The bench drives every input on the falling edge and holds `tz_code` constant around each reset. It makes writes last exactly one clock, so every captured write is a single edge whose effect can be checked both before and after that edge.

// File: rtl/wm_pkg.sv
package wm_pkg;
  localparam logic [7:0] TZ_INVERT = 8'hB4;
  localparam logic [1:0] OFF_CTRL  = 2'd0;
  localparam logic [1:0] OFF_LO    = 2'd1;
  localparam logic [1:0] OFF_HI    = 2'd2;
  localparam int BIT_EN   = 0;
  localparam int BIT_SEC  = 1;
  localparam int BIT_PRIV = 2;
  localparam int BIT_LOCK = 7;

  typedef struct packed {
    logic lock;
    logic priv;
    logic sec;
    logic en;
  } ctrl_t;

  // Attribute rule of an enabled window for one access.
  function automatic logic attr_ok(ctrl_t c, logic is_sec, logic is_priv);
    logic sec_match, priv_match;
    sec_match  = (is_sec == c.sec);
    priv_match = !c.priv || is_priv;
    return sec_match && priv_match;
  endfunction
endpackage

// File: rtl/wm_cfg_regs.sv
module wm_cfg_regs
  import wm_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    tz_code,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output ctrl_t         ctrl_o,
  output logic [AW-1:0] lo_o,
  output logic [AW:0]   hi_o
);
  localparam logic [AW:0] FULL_HI = {1'b1, {AW{1'b0}}};

  ctrl_t         ctrl_q;
  logic [AW-1:0] lo_q;
  logic [AW:0]   hi_q;
  logic          inv_boot;
  logic          wr_accept;
  logic [DW-1:0] wr_data_unused;

  assign inv_boot       = (tz_code == TZ_INVERT);
  assign wr_accept      = wr_en && !ctrl_q.lock;
  assign wr_data_unused = wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.en   <= inv_boot;
      ctrl_q.sec  <= inv_boot;
      ctrl_q.priv <= inv_boot;
      ctrl_q.lock <= 1'b0;
      lo_q        <= '0;
      hi_q        <= inv_boot ? FULL_HI : '0;
    end else if (wr_accept) begin
      case (wr_addr)
        OFF_CTRL: begin
          ctrl_q.en   <= wr_data[BIT_EN];
          ctrl_q.sec  <= wr_data[BIT_SEC];
          ctrl_q.priv <= wr_data[BIT_PRIV];
          ctrl_q.lock <= wr_data[BIT_LOCK];
        end
        OFF_LO:  lo_q <= wr_data[AW-1:0];
        OFF_HI:  hi_q <= wr_data[AW:0];
        default: ;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
  assign lo_o   = lo_q;
  assign hi_o   = hi_q;

  // R9: lock is sticky until reset
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.lock |=> ctrl_q.lock);
  // R9: locked registers ignore writes
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.lock && wr_en) |=> ($stable(ctrl_q) && $stable(lo_q) && $stable(hi_q)));
  // R8: accepted start write lands on the next edge
  a_r8_lo_update: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && wr_addr == OFF_LO) |=> (lo_q == $past(wr_data[AW-1:0])));
endmodule

// File: rtl/wm_access_check.sv
module wm_access_check
  import wm_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl,
  input  logic [AW-1:0] lo,
  input  logic [AW:0]   hi,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_secure,
  input  logic          acc_priv,
  input  logic          base_grant,
  output logic          grant,
  output logic          illegal
);
  function automatic logic in_window(logic [AW-1:0] a, logic [AW-1:0] l, logic [AW:0] h);
    logic [AW:0] a_ext, l_ext;
    a_ext = {1'b0, a};
    l_ext = {1'b0, l};
    return (a_ext >= l_ext) && (a_ext < h);
  endfunction

  logic in_range;
  logic hit;
  logic sub_ok;
  logic allow;

  assign in_range = in_window(acc_addr, lo, hi);
  assign hit      = ctrl.en && in_range;
  assign sub_ok   = attr_ok(ctrl, acc_secure, acc_priv);
  assign allow    = hit ? sub_ok : base_grant;
  assign grant    = acc_valid && allow;
  assign illegal  = acc_valid && !allow;

  // R10: illegal only with a presented, ungranted access
  a_r10_illegal_excl: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (acc_valid && !grant));
  // R3: disabled window passes base decision
  a_r3_disabled_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !ctrl.en) |-> (grant == base_grant));
  // R7: empty window passes base decision
  a_r7_empty_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && ({1'b0, lo} >= hi)) |-> (grant == base_grant));
endmodule

// File: rtl/wm_subregion_filter.sv
module wm_subregion_filter
  import wm_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    tz_code,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_secure,
  input  logic          acc_priv,
  input  logic          base_grant,
  output logic          grant,
  output logic          illegal
);
  ctrl_t         ctrl;
  logic [AW-1:0] lo;
  logic [AW:0]   hi;

  wm_cfg_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .tz_code(tz_code),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_o(ctrl), .lo_o(lo), .hi_o(hi)
  );

  wm_access_check #(.AW(AW)) u_check (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .lo(lo), .hi(hi),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_secure(acc_secure),
    .acc_priv(acc_priv), .base_grant(base_grant),
    .grant(grant), .illegal(illegal)
  );
endmodule

// File: tb/tb_wm_subregion_filter.sv
module tb_wm_subregion_filter;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic [7:0] tz_code = 8'hC3;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [DW-1:0] wr_data = 0;
  logic acc_valid = 0, acc_secure = 0, acc_priv = 0, base_grant = 0;
  logic [AW-1:0] acc_addr = 0;
  logic grant, illegal;
  int checks = 0, fails = 0;

  // bench-side model of the configuration
  logic m_en, m_sec, m_priv, m_lock;
  int   m_lo, m_hi;

  always #4 clk = ~clk;

  wm_subregion_filter #(.AW(AW), .DW(DW)) dut (.*);

  function automatic logic model(int a, logic s, logic p, logic b);
    if (m_en && a >= m_lo && a < m_hi) return (s == m_sec) && (!m_priv || p);
    return b;
  endfunction

  task automatic do_reset(input logic [7:0] code);
    @(negedge clk);
    rst_n = 0; tz_code = code;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_lock = 0;
    if (code == 8'hB4) begin
      m_en = 1; m_sec = 1; m_priv = 1; m_lo = 0; m_hi = 65536;
    end else begin
      m_en = 0; m_sec = 0; m_priv = 0; m_lo = 0; m_hi = 0;
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
    if (!m_lock) begin
      case (a)
        2'd0: begin m_en = d[0]; m_sec = d[1]; m_priv = d[2]; m_lock = d[7]; end
        2'd1: m_lo = d & 32'hFFFF;
        2'd2: m_hi = d & 32'h1FFFF;
        default: ;
      endcase
    end
  endtask

  task automatic check(input string req, input logic g_exp, input logic i_exp);
    checks++;
    if (grant !== g_exp || illegal !== i_exp) begin
      fails++;
      $display("FAIL %s: grant=%b illegal=%b expected grant=%b illegal=%b",
               req, grant, illegal, g_exp, i_exp);
    end
  endtask

  task automatic probe(input string req, input int a, input logic s, input logic p, input logic b);
    logic e;
    @(negedge clk);
    acc_valid = 1; acc_addr = a[AW-1:0]; acc_secure = s; acc_priv = p; base_grant = b;
    #1;
    e = model(a, s, p, b);
    check(req, e, !e);
  endtask

  task automatic t_reset_normal;
    do_reset(8'hC3);
    probe("R1", 0, 0, 0, 1);
    probe("R1", 16'h1234, 1, 1, 0);
    probe("R1", 16'hFFFF, 1, 0, 1);
  endtask

  task automatic t_disabled;
    write_reg(2'd1, 32'h100);
    write_reg(2'd2, 32'h200);
    write_reg(2'd0, 32'h6);           // sec+priv but not enabled
    probe("R3", 32'h150, 0, 0, 1);
    probe("R3", 32'h150, 1, 1, 0);
  endtask

  task automatic t_secure;
    write_reg(2'd0, 32'h3);           // en, secure
    probe("R4", 32'h150, 1, 0, 0);
    probe("R4", 32'h150, 0, 1, 1);
    write_reg(2'd0, 32'h1);           // en, non-secure
    probe("R4", 32'h150, 0, 0, 0);
    probe("R4", 32'h150, 1, 1, 1);
  endtask

  task automatic t_priv;
    write_reg(2'd0, 32'h5);           // en, non-secure, privileged
    probe("R5", 32'h180, 0, 0, 1);
    probe("R5", 32'h180, 0, 1, 0);
    write_reg(2'd0, 32'h1);
    probe("R5", 32'h180, 0, 0, 0);
  endtask

  task automatic t_bounds;
    write_reg(2'd0, 32'h3);           // en, secure: non-secure denied inside
    probe("R6", 32'h0FF, 0, 0, 1);
    probe("R6", 32'h100, 0, 0, 1);
    probe("R6", 32'h1FF, 0, 0, 1);
    probe("R6", 32'h200, 0, 0, 1);
  endtask

  task automatic t_empty;
    write_reg(2'd2, 32'h100);         // end == start
    probe("R7", 32'h100, 0, 0, 1);
    write_reg(2'd2, 32'h80);          // end < start
    probe("R7", 32'h90, 0, 0, 1);
    probe("R7", 32'h100, 0, 0, 1);
    write_reg(2'd2, 32'h200);
  endtask

  task automatic t_timing;
    write_reg(2'd0, 32'h0);
    @(negedge clk);
    acc_valid = 1; acc_addr = 16'h150; acc_secure = 0; acc_priv = 0; base_grant = 1;
    wr_en = 1; wr_addr = 2'd0; wr_data = 32'h3;
    #1 check("R8 before edge", 1'b1, 1'b0);
    @(posedge clk); #1;
    wr_en = 0; m_en = 1; m_sec = 1; m_priv = 0;
    check("R8 after edge", 1'b0, 1'b1);
  endtask

  task automatic t_valid;
    @(negedge clk);
    acc_valid = 0; acc_addr = 16'h150; acc_secure = 0; base_grant = 1;
    #1 check("R10 idle", 1'b0, 1'b0);
    base_grant = 0; acc_addr = 16'h10;
    #1 check("R10 idle", 1'b0, 1'b0);
  endtask

  task automatic t_lock;
    write_reg(2'd0, 32'h83);          // en, secure, lock
    write_reg(2'd0, 32'h0);           // ignored, also tries to clear lock
    write_reg(2'd1, 32'h0);
    write_reg(2'd2, 32'hFFFF);
    probe("R9", 32'h150, 0, 0, 1);    // still enabled+secure
    probe("R9", 32'h050, 0, 0, 1);    // start unchanged
    probe("R9", 32'h300, 0, 0, 1);    // end unchanged
    checks++;
    if (!(m_lock && m_en && m_lo == 32'h100 && m_hi == 32'h200)) begin
      fails++; $display("FAIL R9: model state changed, expected frozen");
    end
  endtask

  task automatic t_inverted;
    do_reset(8'hB4);
    probe("R2", 0, 1, 1, 0);
    probe("R2", 16'hFFFF, 1, 1, 0);
    probe("R2", 16'h8000, 0, 1, 1);
    probe("R2", 16'h8000, 1, 0, 1);
    write_reg(2'd0, 32'h0);           // lock released by reset
    probe("R9 reset clears lock", 16'h8000, 0, 0, 1);
  endtask

  initial begin
    fork
      begin
        t_reset_normal();
        t_disabled();
        t_secure();
        t_priv();
        t_bounds();
        t_empty();
        t_timing();
        t_valid();
        t_lock();
        t_inverted();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule